// File: doc/BRIEF.md
# Fine-Grain Code Write-Protection Cache

This block sits beside the store path of a processor whose translated code is cached away from the original instruction bytes. Any page holding instructions that have already been translated carries a page-level protect flag. That flag arrives with every write. Without finer tracking, any write to such a page would have to fault. The block adds a small, fully associative cache of per-page chunk masks. Each mask has one bit for each 128-byte chunk of a 4 KiB page. A processor write to a protected page faults only when it touches a chunk whose bit is set. Pages that mix code and data therefore stop trapping on their data stores.

Software fills and invalidates entries. When a protected processor write misses the cache, the block reports a miss fault so the handler can load the page's mask from memory and retry. DMA writes are never narrowed to a chunk. Any DMA write to a protected page is reported as touching the whole page. Faults appear on a registered report port one cycle after the write. The report carries the address, a chunk index and a cause code.

Top module: `codeprot_fine_cache`

## Requirements
- R1: After reset no fault is reported and every cache entry is invalid, so the first protected processor write to any page reports a miss.
- R2: A write whose page-protect input is low never produces a fault, and it does not change recency order.
- R3: A fault is reported with `flt_valid` high for exactly the one cycle after the clock edge that sampled the write. `flt_addr` equals the written address, and `flt_cause` is 2'b00 whenever `flt_valid` is low.
- R4: A protected processor write that hits an entry faults with cause 2'b01 (fine hit) only when the mask bit of a touched chunk is set. The chunk index is address bits [11:7].
- R5: A protected processor write whose page is not in the cache faults with cause 2'b10 (miss), reporting the chunk of its first byte.
- R6: A protected DMA write faults with cause 2'b11 (page-wide) whatever the cache holds. It reports the chunk of its first byte and does not change recency order.
- R7: A write covers the bytes from its address to its address plus `wr_len_m1`, and never crosses a page. When those bytes span two chunks, a hit faults if either chunk's bit is set. The reported chunk is the first chunk if its bit is set, otherwise the second.
- R8: A fill (`sw_op` = 0) for a page not in the cache goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the least recently used one.
- R9: A fill for a page already in the cache replaces that entry's mask in place, and never creates a second entry for the page.
- R10: An invalidate (`sw_op` = 1) clears the entry holding the given page, so later writes to it miss. An invalidate for an absent page changes nothing.
- R11: Recency is refreshed by fills and by protected processor writes that hit. When a fill and a hitting write share a cycle, only the filled entry becomes most recent.
- R12: A write sampled in the same cycle as a fill or invalidate is looked up against the cache contents from before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_is_dma | input | 1 | The write comes from a DMA agent rather than the processor |
| wr_page_prot | input | 1 | Page-level protect flag of the written page |
| wr_addr | input | ADDR_W | Byte address of the first written byte |
| wr_len_m1 | input | LEN_W | Number of written bytes minus one |
| sw_valid | input | 1 | A software maintenance operation is presented |
| sw_op | input | 1 | 0 = fill, 1 = invalidate |
| sw_page | input | ADDR_W-PAGE_BITS | Page number the operation targets |
| sw_mask | input | 2**(PAGE_BITS-CHUNK_BITS) | Chunk mask written by a fill |
| flt_valid | output | 1 | A fault is reported this cycle |
| flt_addr | output | ADDR_W | Address of the faulting write |
| flt_chunk | output | PAGE_BITS-CHUNK_BITS | Chunk index of the fault |
| flt_cause | output | 2 | 01 fine hit, 10 miss, 11 page-wide DMA |

## Verification
The checks assume that no write runs past the end of its page. One assertion states this assumption directly. The random stimulus keeps every start offset at least eight bytes below the page end, so all writes satisfy it. The checks also assume that software never fills a page twice through separate paths. The design upholds this itself by steering refills to the existing entry. The stimulus draws from a pool of eight page numbers, twice the cache depth, so it mixes hits, misses, in-place refills, evictions and same-cycle write-and-maintenance collisions. A behavioural model, holding recency as an ordered queue, predicts every output cycle.

// File: rtl/codeprot_pkg.sv
`timescale 1ns/1ps
package codeprot_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_FINE = 2'b01,
        CAUSE_MISS = 2'b10,
        CAUSE_DMA  = 2'b11
    } cp_cause_e;

    localparam logic SWOP_FILL  = 1'b0;
    localparam logic SWOP_INVAL = 1'b1;

endpackage

// File: rtl/cp_span.sv
`timescale 1ns/1ps
module cp_span #(
    parameter  int PAGE_BITS  = 12,
    parameter  int CHUNK_BITS = 7,
    parameter  int LEN_W      = 3,
    localparam int CI_W       = PAGE_BITS - CHUNK_BITS
) (
    input  logic [PAGE_BITS-1:0] offset,
    input  logic [LEN_W-1:0]     len_m1,
    output logic [CI_W-1:0]      first_chunk,
    output logic [CI_W-1:0]      last_chunk
);

    logic [PAGE_BITS-1:0] end_off;

    always_comb begin
        end_off     = offset + {{(PAGE_BITS-LEN_W){1'b0}}, len_m1};
        first_chunk = offset[PAGE_BITS-1:CHUNK_BITS];
        last_chunk  = end_off[PAGE_BITS-1:CHUNK_BITS];
    end

endmodule

// File: rtl/cp_tag_match.sv
`timescale 1ns/1ps
module cp_tag_match #(
    parameter  int ENTRIES = 4,
    parameter  int PN_W    = 20,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][PN_W-1:0]  tags,
    input  logic [PN_W-1:0]               key,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    logic [ENTRIES-1:0] hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // A page may live in at most one entry (refills go in place)
    assert_unique_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/cp_lru.sv
`timescale 1ns/1ps
module cp_lru #(
    parameter  int ENTRIES = 4,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_st_t;

    lru_st_t            st_d, st_q;
    logic [ENTRIES-1:0] oldest_vec;

    always_comb begin
        st_d = st_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < st_q.age[touch_idx]) begin
                    st_d.age[i] = st_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            oldest_vec[i] = (st_q.age[i] == IDX_W'(ENTRIES-1));
            if (oldest_vec[i]) oldest_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    // Ages stay a permutation: exactly one replacement candidate
    assert_single_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // An entry just used is never the next victim
    assert_touch_not_oldest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (oldest_idx != $past(touch_idx)));

endmodule

// File: rtl/codeprot_fine_cache.sv
`timescale 1ns/1ps
module codeprot_fine_cache
    import codeprot_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int PAGE_BITS  = 12,
    parameter  int CHUNK_BITS = 7,
    parameter  int ENTRIES    = 4,
    parameter  int LEN_W      = 3,
    localparam int PN_W       = ADDR_W - PAGE_BITS,
    localparam int CI_W       = PAGE_BITS - CHUNK_BITS,
    localparam int CHUNKS     = 1 << CI_W,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_is_dma,
    input  logic              wr_page_prot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len_m1,
    input  logic              sw_valid,
    input  logic              sw_op,
    input  logic [PN_W-1:0]   sw_page,
    input  logic [CHUNKS-1:0] sw_mask,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [CI_W-1:0]   flt_chunk,
    output logic [1:0]        flt_cause
);

    typedef struct packed {
        logic [ENTRIES-1:0]              vld;
        logic [ENTRIES-1:0][PN_W-1:0]    tag;
        logic [ENTRIES-1:0][CHUNKS-1:0]  mask;
        logic                            flt_v;
        logic [ADDR_W-1:0]               flt_a;
        logic [CI_W-1:0]                 flt_c;
        cp_cause_e                       flt_cause;
    } cpc_st_t;

    cpc_st_t st_d, st_q;

    logic [PN_W-1:0]   wr_pn;
    logic [CI_W-1:0]   first_c, last_c;
    logic              wr_hit, sw_hit;
    logic [IDX_W-1:0]  wr_idx, sw_idx;
    logic [IDX_W-1:0]  oldest_idx, free_idx, fill_idx, touch_idx;
    logic              free_any, touch;
    logic [CHUNKS-1:0] hit_mask;

    assign wr_pn = wr_addr[ADDR_W-1:PAGE_BITS];

    cp_span #(
        .PAGE_BITS (PAGE_BITS),
        .CHUNK_BITS(CHUNK_BITS),
        .LEN_W     (LEN_W)
    ) u_span (
        .offset     (wr_addr[PAGE_BITS-1:0]),
        .len_m1     (wr_len_m1),
        .first_chunk(first_c),
        .last_chunk (last_c)
    );

    cp_tag_match #(.ENTRIES(ENTRIES), .PN_W(PN_W)) u_wr_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (st_q.vld),
        .tags   (st_q.tag),
        .key    (wr_pn),
        .hit    (wr_hit),
        .hit_idx(wr_idx)
    );

    cp_tag_match #(.ENTRIES(ENTRIES), .PN_W(PN_W)) u_sw_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (st_q.vld),
        .tags   (st_q.tag),
        .key    (sw_page),
        .hit    (sw_hit),
        .hit_idx(sw_idx)
    );

    cp_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .oldest_idx(oldest_idx)
    );

    // Lowest-numbered invalid entry
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        if (sw_hit)        fill_idx = sw_idx;
        else if (free_any) fill_idx = free_idx;
        else               fill_idx = oldest_idx;
    end

    always_comb begin
        st_d           = st_q;
        st_d.flt_v     = 1'b0;
        st_d.flt_a     = '0;
        st_d.flt_c     = '0;
        st_d.flt_cause = CAUSE_NONE;
        touch          = 1'b0;
        touch_idx      = wr_idx;
        hit_mask       = st_q.mask[wr_idx];

        if (wr_valid && wr_page_prot) begin
            if (wr_is_dma) begin
                st_d.flt_v     = 1'b1;
                st_d.flt_a     = wr_addr;
                st_d.flt_c     = first_c;
                st_d.flt_cause = CAUSE_DMA;
            end else if (!wr_hit) begin
                st_d.flt_v     = 1'b1;
                st_d.flt_a     = wr_addr;
                st_d.flt_c     = first_c;
                st_d.flt_cause = CAUSE_MISS;
            end else begin
                touch = 1'b1;
                if (hit_mask[first_c]) begin
                    st_d.flt_v     = 1'b1;
                    st_d.flt_a     = wr_addr;
                    st_d.flt_c     = first_c;
                    st_d.flt_cause = CAUSE_FINE;
                end else if (hit_mask[last_c]) begin
                    st_d.flt_v     = 1'b1;
                    st_d.flt_a     = wr_addr;
                    st_d.flt_c     = last_c;
                    st_d.flt_cause = CAUSE_FINE;
                end
            end
        end

        if (sw_valid) begin
            if (sw_op == SWOP_FILL) begin
                st_d.vld[fill_idx]  = 1'b1;
                st_d.tag[fill_idx]  = sw_page;
                st_d.mask[fill_idx] = sw_mask;
                touch               = 1'b1;
                touch_idx           = fill_idx;
            end else if (sw_hit) begin
                st_d.vld[sw_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_valid = st_q.flt_v;
    assign flt_addr  = st_q.flt_a;
    assign flt_chunk = st_q.flt_c;
    assign flt_cause = st_q.flt_cause;

    assert_unprot_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_page_prot) |=> !flt_valid);

    assert_cause_matches_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid == (flt_cause != 2'b00));

    assert_fault_has_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($past(wr_valid && wr_page_prot) && flt_addr == $past(wr_addr)));

    assert_miss_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_page_prot && !wr_is_dma && !wr_hit) |=> (flt_cause == 2'b10));

    assert_dma_pagewide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_page_prot && wr_is_dma) |=> (flt_valid && flt_cause == 2'b11));

    assert_span_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((PAGE_BITS+1)'(wr_addr[PAGE_BITS-1:0]) + (PAGE_BITS+1)'(wr_len_m1)
                      < (PAGE_BITS+1)'(1 << PAGE_BITS)));

    assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_op == SWOP_FILL && !wr_valid) ##1
        (wr_valid && wr_page_prot && !wr_is_dma && wr_pn == $past(sw_page) && !sw_valid)
        |=> (flt_cause != 2'b10));

endmodule

// File: tb/codeprot_fine_cache_bench.sv
`timescale 1ns/1ps
module codeprot_fine_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_is_dma = 1'b0, wr_page_prot = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [2:0]  wr_len_m1 = '0;
    logic        sw_valid = 1'b0, sw_op = 1'b0;
    logic [19:0] sw_page = '0;
    logic [31:0] sw_mask = '0;
    logic        flt_valid;
    logic [31:0] flt_addr;
    logic [4:0]  flt_chunk;
    logic [1:0]  flt_cause;

    always #2.5 clk = ~clk;

    codeprot_fine_cache u_codeprot_fine_cache (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_is_dma(wr_is_dma), .wr_page_prot(wr_page_prot),
        .wr_addr(wr_addr), .wr_len_m1(wr_len_m1),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_page(sw_page), .sw_mask(sw_mask),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_chunk(flt_chunk), .flt_cause(flt_cause)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    bit          m_vld [4];
    logic [19:0] m_tag [4];
    logic [31:0] m_mask[4];
    int          m_ord[$];           // front = most recent
    logic        e_v;
    logic [31:0] e_a;
    logic [4:0]  e_c;
    logic [1:0]  e_cause;
    int          mh, ms, mt, mfc, mlc;

    function automatic int m_find(input logic [19:0] pn);
        for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == pn) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_mask[i] = '0; end
            m_ord = {0, 1, 2, 3};
            e_v = 0; e_a = '0; e_c = '0; e_cause = 2'b00;
        end else begin
            e_v = 0; e_a = '0; e_c = '0; e_cause = 2'b00;
            mt = -1;
            if (wr_valid && wr_page_prot) begin
                mfc = int'(wr_addr[11:0]) / 128;
                mlc = (int'(wr_addr[11:0]) + int'(wr_len_m1)) / 128;
                mh  = m_find(wr_addr[31:12]);
                if (wr_is_dma) begin
                    e_v = 1; e_a = wr_addr; e_c = mfc[4:0]; e_cause = 2'b11;
                end else if (mh < 0) begin
                    e_v = 1; e_a = wr_addr; e_c = mfc[4:0]; e_cause = 2'b10;
                end else begin
                    mt = mh;
                    if (m_mask[mh][mfc]) begin
                        e_v = 1; e_a = wr_addr; e_c = mfc[4:0]; e_cause = 2'b01;
                    end else if (m_mask[mh][mlc]) begin
                        e_v = 1; e_a = wr_addr; e_c = mlc[4:0]; e_cause = 2'b01;
                    end
                end
            end
            if (sw_valid) begin
                ms = m_find(sw_page);
                if (sw_op == 1'b0) begin
                    if (ms < 0) begin
                        for (int i = 3; i >= 0; i--) if (!m_vld[i]) ms = i;
                        if (ms < 0) ms = m_ord[$];
                    end
                    m_vld[ms] = 1; m_tag[ms] = sw_page; m_mask[ms] = sw_mask;
                    mt = ms;
                end else if (ms >= 0) begin
                    m_vld[ms] = 0;
                end
            end
            if (mt >= 0) begin
                for (int k = 0; k < m_ord.size(); k++) begin
                    if (m_ord[k] == mt) begin m_ord.delete(k); break; end
                end
                m_ord.push_front(mt);
            end
        end
    end

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'b01:   return "R4";
            2'b10:   return "R5";
            2'b11:   return "R6";
            default: return "R3";
        endcase
    endfunction

    // Cycle-by-cycle comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (flt_valid !== e_v ||
                (e_v && (flt_addr !== e_a || flt_chunk !== e_c || flt_cause !== e_cause))) begin
                n_fail++;
                $display("FAIL %s model: act v=%0b a=%h c=%0d k=%0d exp v=%0b a=%h c=%0d k=%0d",
                         tag_of(e_cause), flt_valid, flt_addr, flt_chunk, flt_cause,
                         e_v, e_a, e_c, e_cause);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic dchk(input string req, input logic ev, input logic [1:0] ec, input logic [4:0] ek);
        n_chk++;
        if (flt_valid !== ev || (ev && (flt_cause !== ec || flt_chunk !== ek))) begin
            n_fail++;
            $display("FAIL %s: act v=%0b cause=%0d chunk=%0d exp v=%0b cause=%0d chunk=%0d",
                     req, flt_valid, flt_cause, flt_chunk, ev, ec, ek);
        end
    endtask

    task automatic cpu_wr(input logic [19:0] pn, input int off, input int len, input bit prot, input bit dma);
        @(negedge clk);
        wr_valid = 1; wr_addr = {pn, off[11:0]}; wr_len_m1 = len[2:0];
        wr_page_prot = prot; wr_is_dma = dma;
        @(negedge clk);
        wr_valid = 0; wr_is_dma = 0; wr_page_prot = 0;
    endtask

    task automatic sw(input bit op, input logic [19:0] pn, input logic [31:0] mask);
        @(negedge clk);
        sw_valid = 1; sw_op = op; sw_page = pn; sw_mask = mask;
        @(negedge clk);
        sw_valid = 0;
    endtask

    localparam logic [19:0] PA = 20'h00010, PB = 20'h00011, PC = 20'h00012, PD = 20'h00013,
                            PE = 20'h00014, PF = 20'h00015, PG = 20'h00016, PH = 20'h00017;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        dchk("R1", 0, 2'b00, 0);
        cpu_wr(PA, 256, 0, 1, 0);            dchk("R1", 1, 2'b10, 2);
        cpu_wr(PA, 256, 0, 0, 0);            dchk("R2", 0, 2'b00, 0);

        sw(0, PA, 32'h0000_0028);
        cpu_wr(PA, 389, 0, 1, 0);            dchk("R4", 1, 2'b01, 3);
        n_chk++;
        if (flt_addr !== {PA, 12'd389}) begin
            n_fail++; $display("FAIL R3: act addr=%h exp addr=%h", flt_addr, {PA, 12'd389});
        end
        cpu_wr(PA, 522, 1, 1, 0);            dchk("R4", 0, 2'b00, 0);
        cpu_wr(PA, 522, 0, 1, 1);            dchk("R6", 1, 2'b11, 4);

        cpu_wr(PA, 510, 3, 1, 0);            dchk("R7", 1, 2'b01, 3);
        cpu_wr(PA, 638, 3, 1, 0);            dchk("R7", 1, 2'b01, 5);
        cpu_wr(PA, 380, 7, 1, 0);            dchk("R7", 1, 2'b01, 3);
        cpu_wr(PA, 612, 7, 1, 0);            dchk("R7", 0, 2'b00, 0);

        sw(0, PA, 32'h0);
        cpu_wr(PA, 389, 0, 1, 0);            dchk("R9", 0, 2'b00, 0);

        sw(0, PB, 32'hFFFF_FFFF);
        sw(0, PC, 32'hFFFF_FFFF);
        sw(0, PD, 32'hFFFF_FFFF);
        cpu_wr(PA, 0, 0, 1, 0);              dchk("R11", 0, 2'b00, 0);
        sw(0, PE, 32'hFFFF_FFFF);            // evicts B (least recent)
        cpu_wr(PB, 0, 0, 1, 0);              dchk("R8", 1, 2'b10, 0);
        cpu_wr(PA, 0, 0, 1, 0);              dchk("R11", 0, 2'b00, 0);
        cpu_wr(PC, 0, 0, 1, 1);              dchk("R6", 1, 2'b11, 0);
        cpu_wr(PC, 0, 0, 0, 0);              dchk("R2", 0, 2'b00, 0);
        sw(0, PF, 32'hFFFF_FFFF);            // DMA/unprotected writes left C oldest
        cpu_wr(PC, 0, 0, 1, 0);              dchk("R11", 1, 2'b10, 0);
        cpu_wr(PD, 0, 0, 1, 0);              dchk("R11", 1, 2'b01, 0);

        sw(1, PA, 32'h0);
        cpu_wr(PA, 0, 0, 1, 0);              dchk("R10", 1, 2'b10, 0);
        sw(1, 20'hFFFFF, 32'h0);
        cpu_wr(PD, 0, 0, 1, 0);              dchk("R10", 1, 2'b01, 0);
        sw(0, PG, 32'hFFFF_FFFF);            // lands in A's freed entry
        cpu_wr(PE, 0, 0, 1, 0);              dchk("R8", 1, 2'b01, 0);

        @(negedge clk);
        wr_valid = 1; wr_addr = {PH, 12'd0}; wr_len_m1 = 0; wr_page_prot = 1; wr_is_dma = 0;
        sw_valid = 1; sw_op = 0; sw_page = PH; sw_mask = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_valid = 0; sw_valid = 0; wr_page_prot = 0;
        dchk("R12", 1, 2'b10, 0);
        cpu_wr(PH, 0, 0, 1, 0);              dchk("R12", 1, 2'b01, 0);

        // Random traffic checked against the model every cycle (R8..R12 collisions)
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            wr_valid     = ($urandom % 10) < 6;
            wr_page_prot = ($urandom % 10) < 8;
            wr_is_dma    = ($urandom % 100) < 15;
            wr_addr      = {PA + 20'($urandom % 8), 12'($urandom % 4089)};
            wr_len_m1    = 3'($urandom);
            sw_valid     = ($urandom % 10) < 2;
            sw_op        = ($urandom % 10) < 3;
            sw_page      = PA + 20'($urandom % 8);
            sw_mask      = (($urandom % 4) == 0) ? 32'h0 : 32'($urandom);
        end
        @(negedge clk);
        wr_valid = 0; sw_valid = 0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule